// File: doc/BRIEF.md
# External Interrupt Polarity Conditioner

This block sits between three external interrupt pins and a downstream interrupt controller that understands only active-high levels and rising edges. Each pin is brought into the clock domain through a synchronizer. It is then sampled by a detector whose rate depends on a per-line clock-select bit. The detector turns active-low levels into active-high ones and falling edges into rising events, so the downstream controller never sees any other form.

Each line is controlled by an 8-bit field. The three fields share one 32-bit register behind a plain word-wide write strobe and a read bus that always shows the register. In the two edge modes an event sets a sticky pending flag. Software clears that flag by writing a one to it, and the line's output is the pending flag gated by the enable bit. In the two level modes the conditioned pin level drives the output directly, also gated by enable. The register port carries only control and status, so it has no valid/ready handshake and never stalls. A write takes effect at the clock edge where `cfg_wr` is high.

Top module: `extirq_conditioner`

## Requirements
- R1: After reset every field is zero (disabled, active-high level, default sampling, pending clear), `cfg_rdata` reads 0 and `irq_out` is 0.
- R2: Line 0's field sits at register bits 23:16, line 1's at 15:8 and line 2's at 7:0. Inside a field, bit 0 is pending, bit 4 is clock select, bit 5 is enable and bits 7:6 are the trigger type. Bits 31:24 and each field's bits 3:1 read as zero and ignore writes.
- R3: With trigger type 00 (active-high level) and enable set, `irq_out[i]` follows the synchronized pin. With the default two synchronizer stages and fast sampling, a pin change shows on the output after three clock edges.
- R4: With trigger type 01 (active-low level) and enable set, `irq_out[i]` is the inverse of the synchronized pin.
- R5: With trigger type 10 (rising edge), a sampled 0-to-1 transition sets the line's pending bit. While enabled, `irq_out[i]` equals that bit.
- R6: With trigger type 11 (falling edge), a sampled 1-to-0 transition sets the pending bit and a 0-to-1 transition does not.
- R7: The pending bit stays set until a write puts a 1 in it. Writing 0 to it has no effect.
- R8: While enable is clear, `irq_out[i]` is 0. Pending events are still recorded and appear on the output once the line is enabled again.
- R9: A write that changes a line's trigger type clears that line's pending bit. In level modes the pending bit always reads 0.
- R10: With clock select set, the detector samples on every cycle. With it clear, the detector samples only on cycles where `slow_tick` is high.
- R11: The three lines are independent: each output depends only on its own pin and its own field.
- R12: When an edge event and a write-one-to-clear of the same pending bit happen in the same cycle, the pending bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 3 | Raw external interrupt pins, bit i is line i |
| slow_tick | input | 1 | Sampling strobe used by lines whose clock select is clear |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Current register contents |
| irq_out | output | 3 | Conditioned active-high or rising-event outputs, bit i is line i |

## Verification
The bench builds the block with its default parameters: three lines, 8-bit fields, a 32-bit register and two synchronizer stages. Because the synchronizer has two stages, every pin-to-output check can be placed exactly three edges after the pin moves. The same fixed delay lets the bench line up an edge event with a clearing write in the same cycle, which is how the set-over-clear priority is tested. Keeping the lines at three exposes the reserved top byte, so the bench can confirm that it ignores writes.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int FIELD_W  = 8;
  localparam int BIT_PEND = 0;
  localparam int BIT_CSEL = 4;
  localparam int BIT_EN   = 5;
  localparam int BIT_TLO  = 6;
  localparam int BIT_THI  = 7;

  typedef enum logic [1:0] {
    TRIG_LVL_HIGH = 2'b00,
    TRIG_LVL_LOW  = 2'b01,
    TRIG_EDGE_UP  = 2'b10,
    TRIG_EDGE_DN  = 2'b11
  } trig_e;

  function automatic int field_lsb(input int line, input int lines);
    return (lines - 1 - line) * FIELD_W;
  endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/extirq_line.sv
module extirq_line
  import extirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wfield,
  input  logic               sync_in,
  input  logic               slow_tick,
  output logic [FIELD_W-1:0] field_q,
  output logic               irq_out
);

  trig_e trig_q;
  logic  en_q, csel_q, pend_q, cur_q;

  logic  strobe, rise, fall, edge_mode, evt, type_chg, clr_req, lvl;
  trig_e trig_w;

  assign strobe    = csel_q | slow_tick;
  assign rise      = strobe &  sync_in & ~cur_q;
  assign fall      = strobe & ~sync_in &  cur_q;
  assign edge_mode = trig_q[1];
  assign evt       = edge_mode & (trig_q[0] ? fall : rise);
  assign trig_w    = trig_e'(wfield[BIT_THI:BIT_TLO]);
  assign type_chg  = wr_en && (trig_w != trig_q);
  assign clr_req   = wr_en && wfield[BIT_PEND];
  assign lvl       = cur_q ^ trig_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q <= TRIG_LVL_HIGH;
      en_q   <= 1'b0;
      csel_q <= 1'b0;
    end else if (wr_en) begin
      trig_q <= trig_w;
      en_q   <= wfield[BIT_EN];
      csel_q <= wfield[BIT_CSEL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= 1'b0;
    else if (strobe) cur_q <= sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend_q <= 1'b0;
    else if (type_chg)          pend_q <= 1'b0;
    else if (evt)               pend_q <= 1'b1;
    else if (clr_req)           pend_q <= 1'b0;
  end

  assign field_q = {trig_q, en_q, csel_q, 3'b000, pend_q};
  assign irq_out = en_q & (edge_mode ? pend_q : lvl);

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_out);
  assert_level_no_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_q[1] |-> !pend_q);
  assert_edge_latches_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !type_chg) |=> pend_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_en) |=> pend_q);
  assert_sample_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cur_q));

endmodule

// File: rtl/extirq_conditioner.sv
module extirq_conditioner
  import extirq_pkg::*;
#(
  parameter int NUM_LINES   = 3,
  parameter int REG_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pin_in,
  input  logic                 slow_tick,
  input  logic                 cfg_wr,
  input  logic [REG_W-1:0]     cfg_wdata,
  output logic [REG_W-1:0]     cfg_rdata,
  output logic [NUM_LINES-1:0] irq_out
);

  localparam int FIELDS_W = NUM_LINES * FIELD_W;
  localparam int PAD_W    = REG_W - FIELDS_W;

  logic [NUM_LINES-1:0] pin_sync;
  logic [FIELDS_W-1:0]  fields_flat;

  extirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_in),
    .dout (pin_sync)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam int LSB = field_lsb(g, NUM_LINES);
    extirq_line u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr),
      .wfield   (cfg_wdata[LSB +: FIELD_W]),
      .sync_in  (pin_sync[g]),
      .slow_tick(slow_tick),
      .field_q  (fields_flat[LSB +: FIELD_W]),
      .irq_out  (irq_out[g])
    );
  end

  if (PAD_W > 0) begin : g_pad
    assign cfg_rdata = {{PAD_W{1'b0}}, fields_flat};
  end else begin : g_nopad
    assign cfg_rdata = fields_flat[REG_W-1:0];
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata[FIELD_W*NUM_LINES-1 -: 2] == $past(cfg_wdata[FIELD_W*NUM_LINES-1 -: 2])));

endmodule

// File: tb/extirq_conditioner_test.sv
module extirq_conditioner_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pin_in = '0;
  logic        slow_tick = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [2:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  extirq_conditioner uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .slow_tick(slow_tick),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic [2:0]  pins;
    logic [2:0]  exp;
  } vec_t;

  // level-mode table, fields: 0x30 high+en+fast, 0x70 low+en+fast, 0x50/0x10 disabled
  localparam vec_t VECS [8] = '{
    '{32'h00303030, 3'b000, 3'b000},
    '{32'h00303030, 3'b101, 3'b101},
    '{32'h00707070, 3'b000, 3'b111},
    '{32'h00707070, 3'b011, 3'b100},
    '{32'h00305070, 3'b000, 3'b100},
    '{32'h00305070, 3'b111, 3'b001},
    '{32'h00103070, 3'b110, 3'b010},
    '{32'h00707030, 3'b010, 3'b001}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", cfg_rdata, 32'h0);
    check("R1 irq", {29'd0, irq_out}, 32'h0);
    rst_n = 1'b1;
    settle();

    // R3 R4 R11 level table with readback (R2)
    for (int i = 0; i < 8; i++) begin
      write_reg(VECS[i].cfg);
      pin_in = VECS[i].pins;
      settle();
      check("R3/R4 R11 level irq", {29'd0, irq_out}, {29'd0, VECS[i].exp});
      check("R2 readback", cfg_rdata, VECS[i].cfg);
    end

    // R2 reserved bits ignore writes
    write_reg(32'hFFFFFFFF);
    check("R2 reserved", cfg_rdata, 32'h00F0F0F0);
    check("R2 edge idle irq", {29'd0, irq_out}, 32'h0);

    // R5 rising edge on line 1, R7 sticky and write-one-to-clear
    write_reg(32'h0000B000);
    pin_in = 3'b000;
    settle();
    pin_in = 3'b010;
    settle();
    check("R5 rise irq", {29'd0, irq_out}, 32'h2);
    check("R5 pending bit", cfg_rdata, 32'h0000B100);
    pin_in = 3'b000;
    settle();
    check("R7 sticky after fall", {29'd0, irq_out}, 32'h2);
    write_reg(32'h0000B000);
    check("R7 write zero no effect", cfg_rdata, 32'h0000B100);
    write_reg(32'h0000B100);
    check("R7 cleared", cfg_rdata, 32'h0000B000);
    check("R7 irq low", {29'd0, irq_out}, 32'h0);

    // R6 falling edge on line 2
    write_reg(32'h000000F0);
    pin_in = 3'b100;
    settle();
    check("R6 rise ignored", {29'd0, irq_out}, 32'h0);
    pin_in = 3'b000;
    settle();
    check("R6 fall irq", {29'd0, irq_out}, 32'h4);

    // R8 mask keeps pending, unmask restores
    write_reg(32'h000000D0);
    check("R8 masked irq", {29'd0, irq_out}, 32'h0);
    check("R8 pending kept", cfg_rdata, 32'h000000D1);
    write_reg(32'h000000F0);
    check("R8 unmasked irq", {29'd0, irq_out}, 32'h4);

    // R9 type change clears pending
    write_reg(32'h000000B0);
    check("R9 type change clears", cfg_rdata, 32'h000000B0);

    // R10 slow sampling on line 0
    write_reg(32'h00200000);
    pin_in = 3'b001;
    repeat (6) @(negedge clk);
    check("R10 no tick no sample", {29'd0, irq_out}, 32'h0);
    slow_tick = 1'b1;
    @(negedge clk);
    slow_tick = 1'b0;
    check("R10 tick samples", {29'd0, irq_out}, 32'h1);

    // R12 edge event and clear in the same cycle
    write_reg(32'h00B00000);
    pin_in = 3'b000;
    settle();
    pin_in = 3'b001;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b1;
    cfg_wdata = 32'h00B10000;
    @(negedge clk);
    cfg_wr = 1'b0;
    check("R12 set wins", cfg_rdata, 32'h00B10000);
    write_reg(32'h00B10000);
    check("R12 later clear", cfg_rdata, 32'h00B00000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule